// File: doc/BRIEF.md
# Predicated Three-Way De-Interleaving Loader

This block walks an array of records in memory, each record being three consecutive 64-bit words, and spreads them over three vector result registers. Record `e` lands in element slot `e` of every result: its first word in result 0, its second in result 1 and its third in result 2. One predicate bit per slot decides whether the record is fetched at all. A slot whose bit is clear causes no memory traffic and reads back as zero in all three results.

A caller supplies a 64-bit base, a 64-bit starting index, the predicate mask, the index selector, a flag saying the base came from the stack pointer, and a 5-bit destination number, then pulses start. The block issues single reads on a valid/ready request channel, collects the words on a valid/ready response channel, and pulses done when all three vectors are complete. The vector length is a parameter; the slot count is that length divided by 64.

Top module: `tri_deint_loader`

## Requirements
- R1: With N = VEC_BITS/64 slots, active record e reads its words w = 0, 1, 2 at byte address base + 8·(index + 3·e) + 8·w. Records go in ascending e, words in ascending w, and no other reads are issued.
- R2: The word read for record e, word w is placed in bits [64·e+63 : 64·e] of result vector w (vecOut0, vecOut1, vecOut2).
- R3: When predicate bit e is 0, no read is issued for record e and bits [64·e+63 : 64·e] of all three result vectors are zero.
- R4: The destination numbers presented are t, (t+1) mod 32 and (t+2) mod 32, where t is the 5-bit dstSel captured at the accepted start.
- R5: A start with idxSel equal to 31 is refused: illegalOp is high for exactly the one cycle after the start edge, no read and no done follow, and the result vectors and destination numbers keep their values.
- R6: A start with baseIsSp set, at least one predicate bit set and baseAddr[3:0] not zero is refused: alignErr pulses for one cycle, no read and no done follow. With no predicate bit set, the same base is accepted and completes with all-zero results.
- R7: At most one read is outstanding: a request is never presented while a response is awaited, and a request waiting for ready keeps its address unchanged.
- R8: doneStrobe is high for exactly one cycle per accepted start. The result vectors stay unchanged from done until the next accepted start, and a start raised while an operation is in progress has no effect.
- R9: Address arithmetic wraps modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | One-cycle start pulse |
| baseAddr | input | 64 | Byte base address |
| baseIsSp | input | 1 | Base was taken from the stack pointer |
| elemIndex | input | 64 | Starting index in 64-bit words; not modified |
| idxSel | input | 5 | Index register selector; 31 is illegal |
| predMask | input | VEC_BITS/64 | One predicate bit per slot |
| dstSel | input | 5 | First destination register number |
| rdReqValid | output | 1 | Read request valid |
| rdReqReady | input | 1 | Read request accepted |
| rdReqAddr | output | 64 | Read byte address |
| rdRspValid | input | 1 | Read data valid |
| rdRspReady | output | 1 | Ready for read data |
| rdRspData | input | 64 | Read data word |
| vecOut0 | output | VEC_BITS | Result vector for word 0 of each record |
| vecOut1 | output | VEC_BITS | Result vector for word 1 of each record |
| vecOut2 | output | VEC_BITS | Result vector for word 2 of each record |
| dstReg0 | output | 5 | Destination number of vecOut0 |
| dstReg1 | output | 5 | Destination number of vecOut1 |
| dstReg2 | output | 5 | Destination number of vecOut2 |
| doneStrobe | output | 1 | One-cycle completion pulse |
| illegalOp | output | 1 | One-cycle refusal pulse for selector 31 |
| alignErr | output | 1 | One-cycle refusal pulse for a misaligned stack base |

## Verification
The load is tried with a fully active mask, an alternating mask, and an all-clear mask that follows a full load, so that a misplaced word, a read issued for a skipped slot, and stale data left in a skipped slot each show up as a distinct mismatch. A base near the top of the address space separates wrapping arithmetic from saturating or widened sums, and a destination of 30 separates the mod-32 wrap from plain addition. The refusal paths are tried with a misaligned stack base both with and without active bits, which tells the alignment rule apart from a blanket check on the base. The memory model stalls both channels on a fixed pattern so that address holding and the single-outstanding rule are exercised.

// File: rtl/tri_deint_pkg.sv
package tri_deint_pkg;

  localparam int ELEM_BITS = 64;
  localparam int REC_WORDS = 3;
  localparam int WORD_BYTES = ELEM_BITS / 8;
  localparam int REG_SEL_BITS = 5;
  localparam logic [REG_SEL_BITS-1:0] BAD_IDX_SEL = '1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_REQ,
    ST_RSP,
    ST_DONE
  } ldState_t;

  typedef struct packed {
    logic loadOp;    // accepted start: seed address, clear results, latch targets
    logic stepWord;  // one word consumed: advance address by one word
    logic stepSkip;  // inactive record: advance address by a whole record
    logic capture;   // write response word into its slot
  } dpStrobe_t;

endpackage

// File: rtl/tri_deint_ctrl.sv
module tri_deint_ctrl
  import tri_deint_pkg::*;
#(
  parameter int NUM_ELEMS = 4,
  parameter int ELEM_IDX_BITS = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       startReq,
  input  logic                       baseIsSp,
  input  logic [3:0]                 baseLow,
  input  logic [REG_SEL_BITS-1:0]    idxSel,
  input  logic [NUM_ELEMS-1:0]       predMask,
  input  logic                       rdReqReady,
  input  logic                       rdRspValid,
  output logic                       rdReqValid,
  output logic                       rdRspReady,
  output logic                       doneStrobe,
  output logic                       illegalOp,
  output logic                       alignErr,
  output dpStrobe_t                  strobe,
  output logic [ELEM_IDX_BITS-1:0]   elemIdx,
  output logic [1:0]                 wordIdx
);

  localparam logic [ELEM_IDX_BITS-1:0] LAST_ELEM = ELEM_IDX_BITS'(NUM_ELEMS - 1);
  localparam logic [1:0] LAST_WORD = 2'(REC_WORDS - 1);

  ldState_t stateQ, stateD;
  logic [NUM_ELEMS-1:0]     maskQ;
  logic [ELEM_IDX_BITS-1:0] elemQ;
  logic [1:0]               wordQ;
  logic                     illegalQ, alignQ;

  logic badSel, misaligned, lastElem, lastWord, acceptStart;

  assign badSel      = (idxSel == BAD_IDX_SEL);
  assign misaligned  = baseIsSp && (|predMask) && (|baseLow);
  assign lastElem    = (elemQ == LAST_ELEM);
  assign lastWord    = (wordQ == LAST_WORD);
  assign acceptStart = (stateQ == ST_IDLE) && startReq && !badSel && !misaligned;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    rdReqValid = 1'b0;
    rdRspReady = 1'b0;
    doneStrobe = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (acceptStart) begin
          strobe.loadOp = 1'b1;
          stateD = ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (maskQ[elemQ]) begin
          stateD = ST_REQ;
        end else begin
          strobe.stepSkip = 1'b1;
          if (lastElem) stateD = ST_DONE;
        end
      end
      ST_REQ: begin
        rdReqValid = 1'b1;
        if (rdReqReady) stateD = ST_RSP;
      end
      ST_RSP: begin
        rdRspReady = 1'b1;
        if (rdRspValid) begin
          strobe.capture  = 1'b1;
          strobe.stepWord = 1'b1;
          if (!lastWord)     stateD = ST_REQ;
          else if (lastElem) stateD = ST_DONE;
          else               stateD = ST_SCAN;
        end
      end
      ST_DONE: begin
        doneStrobe = 1'b1;
        stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      maskQ    <= '0;
      elemQ    <= '0;
      wordQ    <= '0;
      illegalQ <= 1'b0;
      alignQ   <= 1'b0;
    end else begin
      stateQ   <= stateD;
      illegalQ <= (stateQ == ST_IDLE) && startReq && badSel;
      alignQ   <= (stateQ == ST_IDLE) && startReq && !badSel && misaligned;
      if (strobe.loadOp) begin
        maskQ <= predMask;
        elemQ <= '0;
        wordQ <= '0;
      end else if (strobe.stepSkip) begin
        if (!lastElem) elemQ <= elemQ + 1'b1;
      end else if (strobe.capture) begin
        if (lastWord) begin
          wordQ <= '0;
          if (!lastElem) elemQ <= elemQ + 1'b1;
        end else begin
          wordQ <= wordQ + 1'b1;
        end
      end
    end
  end

  assign illegalOp = illegalQ;
  assign alignErr  = alignQ;
  assign elemIdx   = elemQ;
  assign wordIdx   = wordQ;

  // A refused start must never lead into memory traffic or completion.
  assert_refuse_illegal_R5: assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |-> (!rdReqValid && !doneStrobe && stateQ == ST_IDLE));

  assert_refuse_align_R6: assert property (@(posedge clk) disable iff (!rstN)
    alignErr |-> (!rdReqValid && !doneStrobe && stateQ == ST_IDLE));

  // Requests only ever belong to records whose predicate bit is set.
  assert_req_active_only_R3: assert property (@(posedge clk) disable iff (!rstN)
    rdReqValid |-> maskQ[elemQ]);

  // Never a request while a response is still awaited.
  assert_single_outstanding_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdReqValid && rdReqReady) |=> (!rdReqValid && rdRspReady));

endmodule

// File: rtl/tri_deint_dpath.sv
module tri_deint_dpath
  import tri_deint_pkg::*;
#(
  parameter int NUM_ELEMS = 4,
  parameter int ELEM_IDX_BITS = 2,
  parameter int ADDR_BITS = 64
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  dpStrobe_t                       strobe,
  input  logic [ELEM_IDX_BITS-1:0]        elemIdx,
  input  logic [1:0]                      wordIdx,
  input  logic [ADDR_BITS-1:0]            baseAddr,
  input  logic [ADDR_BITS-1:0]            elemIndex,
  input  logic [REG_SEL_BITS-1:0]         dstSel,
  input  logic [ELEM_BITS-1:0]            rdRspData,
  output logic [ADDR_BITS-1:0]            rdReqAddr,
  output logic [NUM_ELEMS*ELEM_BITS-1:0]  vecFlat [REC_WORDS],
  output logic [REG_SEL_BITS-1:0]         dstNum [REC_WORDS]
);

  localparam int SHIFT = $clog2(WORD_BYTES);
  localparam logic [ADDR_BITS-1:0] WORD_STEP = ADDR_BITS'(WORD_BYTES);
  localparam logic [ADDR_BITS-1:0] REC_STEP  = ADDR_BITS'(WORD_BYTES * REC_WORDS);

  logic [ADDR_BITS-1:0] curAddr;
  logic [ELEM_BITS-1:0] slotQ [REC_WORDS][NUM_ELEMS];
  logic [REG_SEL_BITS-1:0] dstQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr <= '0;
      dstQ    <= '0;
    end else if (strobe.loadOp) begin
      curAddr <= baseAddr + (elemIndex << SHIFT);
      dstQ    <= dstSel;
    end else if (strobe.stepSkip) begin
      curAddr <= curAddr + REC_STEP;
    end else if (strobe.stepWord) begin
      curAddr <= curAddr + WORD_STEP;
    end
  end

  genvar w, e;
  generate
    for (w = 0; w < REC_WORDS; w++) begin : gWord
      for (e = 0; e < NUM_ELEMS; e++) begin : gElem
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            slotQ[w][e] <= '0;
          end else if (strobe.loadOp) begin
            slotQ[w][e] <= '0;
          end else if (strobe.capture && wordIdx == 2'(w) &&
                       elemIdx == ELEM_IDX_BITS'(e)) begin
            slotQ[w][e] <= rdRspData;
          end
        end
        assign vecFlat[w][e*ELEM_BITS +: ELEM_BITS] = slotQ[w][e];
      end
      assign dstNum[w] = dstQ + REG_SEL_BITS'(w);
    end
  endgenerate

  assign rdReqAddr = curAddr;

  // Results only change on an accepted start or on a captured word.
  assert_results_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.loadOp || strobe.capture) |=>
      ($stable(vecFlat[0]) && $stable(vecFlat[1]) && $stable(vecFlat[2])));

endmodule

// File: rtl/tri_deint_loader.sv
module tri_deint_loader
  import tri_deint_pkg::*;
#(
  parameter int VEC_BITS = 256,
  parameter int ADDR_BITS = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startReq,
  input  logic [ADDR_BITS-1:0] baseAddr,
  input  logic                 baseIsSp,
  input  logic [ADDR_BITS-1:0] elemIndex,
  input  logic [4:0]           idxSel,
  input  logic [VEC_BITS/64-1:0] predMask,
  input  logic [4:0]           dstSel,
  output logic                 rdReqValid,
  input  logic                 rdReqReady,
  output logic [ADDR_BITS-1:0] rdReqAddr,
  input  logic                 rdRspValid,
  output logic                 rdRspReady,
  input  logic [63:0]          rdRspData,
  output logic [VEC_BITS-1:0]  vecOut0,
  output logic [VEC_BITS-1:0]  vecOut1,
  output logic [VEC_BITS-1:0]  vecOut2,
  output logic [4:0]           dstReg0,
  output logic [4:0]           dstReg1,
  output logic [4:0]           dstReg2,
  output logic                 doneStrobe,
  output logic                 illegalOp,
  output logic                 alignErr
);

  localparam int NUM_ELEMS = VEC_BITS / ELEM_BITS;
  localparam int ELEM_IDX_BITS = (NUM_ELEMS > 1) ? $clog2(NUM_ELEMS) : 1;

  dpStrobe_t strobe;
  logic [ELEM_IDX_BITS-1:0] elemIdx;
  logic [1:0] wordIdx;
  logic [VEC_BITS-1:0] vecFlat [REC_WORDS];
  logic [4:0] dstNum [REC_WORDS];

  tri_deint_ctrl #(
    .NUM_ELEMS(NUM_ELEMS),
    .ELEM_IDX_BITS(ELEM_IDX_BITS)
  ) ctrl_i (
    .clk(clk),
    .rstN(rstN),
    .startReq(startReq),
    .baseIsSp(baseIsSp),
    .baseLow(baseAddr[3:0]),
    .idxSel(idxSel),
    .predMask(predMask),
    .rdReqReady(rdReqReady),
    .rdRspValid(rdRspValid),
    .rdReqValid(rdReqValid),
    .rdRspReady(rdRspReady),
    .doneStrobe(doneStrobe),
    .illegalOp(illegalOp),
    .alignErr(alignErr),
    .strobe(strobe),
    .elemIdx(elemIdx),
    .wordIdx(wordIdx)
  );

  tri_deint_dpath #(
    .NUM_ELEMS(NUM_ELEMS),
    .ELEM_IDX_BITS(ELEM_IDX_BITS),
    .ADDR_BITS(ADDR_BITS)
  ) dpath_i (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .elemIdx(elemIdx),
    .wordIdx(wordIdx),
    .baseAddr(baseAddr),
    .elemIndex(elemIndex),
    .dstSel(dstSel),
    .rdRspData(rdRspData),
    .rdReqAddr(rdReqAddr),
    .vecFlat(vecFlat),
    .dstNum(dstNum)
  );

  assign vecOut0 = vecFlat[0];
  assign vecOut1 = vecFlat[1];
  assign vecOut2 = vecFlat[2];
  assign dstReg0 = dstNum[0];
  assign dstReg1 = dstNum[1];
  assign dstReg2 = dstNum[2];

  // A stalled request keeps its address.
  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdReqValid && !rdReqReady) |=> (rdReqValid && $stable(rdReqAddr)));

  // Completion is a single-cycle pulse.
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    doneStrobe |=> !doneStrobe);

endmodule

// File: tb/tri_deint_loader_tb_top.sv
module tri_deint_loader_tb_top;

  localparam int VEC_BITS = 256;
  localparam int NE = VEC_BITS / 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [63:0] baseAddr = '0;
  logic baseIsSp = 1'b0;
  logic [63:0] elemIndex = '0;
  logic [4:0] idxSel = 5'd2;
  logic [NE-1:0] predMask = '0;
  logic [4:0] dstSel = '0;
  logic rdReqValid, rdRspReady;
  logic rdReqReady = 1'b0;
  logic [63:0] rdReqAddr;
  logic rdRspValid = 1'b0;
  logic [63:0] rdRspData = '0;
  logic [VEC_BITS-1:0] vecOut0, vecOut1, vecOut2;
  logic [4:0] dstReg0, dstReg1, dstReg2;
  logic doneStrobe, illegalOp, alignErr;

  always #5 clk = ~clk;

  tri_deint_loader #(.VEC_BITS(VEC_BITS)) dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .baseAddr(baseAddr),
    .baseIsSp(baseIsSp), .elemIndex(elemIndex), .idxSel(idxSel),
    .predMask(predMask), .dstSel(dstSel), .rdReqValid(rdReqValid),
    .rdReqReady(rdReqReady), .rdReqAddr(rdReqAddr), .rdRspValid(rdRspValid),
    .rdRspReady(rdRspReady), .rdRspData(rdRspData), .vecOut0(vecOut0),
    .vecOut1(vecOut1), .vecOut2(vecOut2), .dstReg0(dstReg0), .dstReg1(dstReg1),
    .dstReg2(dstReg2), .doneStrobe(doneStrobe), .illegalOp(illegalOp),
    .alignErr(alignErr)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [63:0] addrLog [64];
  int readCount = 0;
  logic [63:0] expAddr [64];
  int expCnt = 0;
  logic [VEC_BITS-1:0] expVec [3];

  function automatic logic [63:0] memData(input logic [63:0] a);
    return {a[31:0] ^ 32'hC0DE_5A5A, ~a[31:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [VEC_BITS-1:0] act,
                     input logic [VEC_BITS-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Memory model: decisions at the falling edge, fires at the next rising edge.
  bit rspPend = 1'b0, rspFireNext = 1'b0, reqFireNext = 1'b0;
  logic [63:0] pendAddr = '0, lastAddr = '0;
  int stallCnt = 0;
  initial begin
    forever begin
      @(negedge clk);
      stallCnt++;
      if (rspFireNext) begin rdRspValid = 1'b0; rspFireNext = 1'b0; end
      if (reqFireNext) begin rspPend = 1'b1; pendAddr = lastAddr; reqFireNext = 1'b0; end
      if (rdReqValid && rdRspReady) chk(1'b0, "R7 req during rsp wait", 1, 0);
      if (rspPend && (stallCnt % 4 != 2)) begin
        rdRspValid = 1'b1;
        rdRspData = memData(pendAddr);
        if (rdRspReady) begin rspFireNext = 1'b1; rspPend = 1'b0; end
      end
      rdReqReady = (stallCnt % 3 != 1) && rstN;
      if (rdReqValid && rdReqReady) begin
        reqFireNext = 1'b1;
        lastAddr = rdReqAddr;
        if (readCount < 64) addrLog[readCount] = rdReqAddr;
        readCount++;
      end
    end
  end

  task automatic buildExp(input logic [63:0] b, input logic [63:0] ix, input logic [NE-1:0] m);
    expCnt = 0;
    for (int w = 0; w < 3; w++) expVec[w] = '0;
    for (int e = 0; e < NE; e++) begin
      if (m[e]) begin
        for (int w = 0; w < 3; w++) begin
          logic [63:0] a;
          a = b + ((ix + 64'(3 * e)) << 3) + 64'(8 * w);
          expAddr[expCnt] = a;
          expCnt++;
          expVec[w][e*64 +: 64] = memData(a);
        end
      end
    end
  endtask

  task automatic pulseStart(input logic [63:0] b, input bit sp, input logic [63:0] ix,
                            input logic [4:0] isel, input logic [NE-1:0] m, input logic [4:0] d);
    @(negedge clk);
    baseAddr = b; baseIsSp = sp; elemIndex = ix; idxSel = isel; predMask = m; dstSel = d;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic waitDone(input string tag, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 400 && !seen; i++) begin
      if (doneStrobe) seen = 1'b1;
      else @(negedge clk);
    end
    chk(seen, {tag, " done seen"}, 0, 1);
    if (seen) begin
      @(negedge clk);
      chk(!doneStrobe, "R8 done one cycle", 256'(doneStrobe), 0);
    end
  endtask

  task automatic verifyOp(input string tag, input int rc0, input logic [4:0] d);
    chk(readCount - rc0 == expCnt, {tag, " read count"}, 256'(readCount - rc0), 256'(expCnt));
    for (int i = 0; i < expCnt && (rc0 + i) < 64; i++)
      chk(addrLog[rc0 + i] == expAddr[i], {"R1 address order ", tag},
          256'(addrLog[rc0 + i]), 256'(expAddr[i]));
    chk(vecOut0 == expVec[0], {"R2 vec0 ", tag}, vecOut0, expVec[0]);
    chk(vecOut1 == expVec[1], {"R2 vec1 ", tag}, vecOut1, expVec[1]);
    chk(vecOut2 == expVec[2], {"R2 vec2 ", tag}, vecOut2, expVec[2]);
    chk(dstReg0 == d && dstReg1 == 5'(d + 1) && dstReg2 == 5'(d + 2), {"R4 dst ", tag},
        256'({dstReg0, dstReg1, dstReg2}), 256'({d, 5'(d + 1), 5'(d + 2)}));
  endtask

  task automatic runOp(input string tag, input logic [63:0] b, input bit sp,
                       input logic [63:0] ix, input logic [NE-1:0] m, input logic [4:0] d);
    int rc0;
    bit seen;
    rc0 = readCount;
    buildExp(b, ix, m);
    pulseStart(b, sp, ix, 5'd4, m, d);
    waitDone(tag, seen);
    verifyOp(tag, rc0, d);
  endtask

  task automatic tReset;
    @(negedge clk);
    chk(vecOut0 == 0 && vecOut1 == 0 && vecOut2 == 0, "R8 reset results", vecOut0, 0);
    chk(!doneStrobe && !rdReqValid && !illegalOp && !alignErr, "R8 reset controls",
        256'({doneStrobe, rdReqValid, illegalOp, alignErr}), 0);
  endtask

  task automatic tAllActive;
    runOp("R1 all active", 64'h0000_0000_0000_1000, 1'b0, 64'd5, 4'b1111, 5'd3);
  endtask

  task automatic tMixed;
    runOp("R3 alternating", 64'h0000_0040_0000_0200, 1'b0, 64'd17, 4'b0101, 5'd9);
  endtask

  task automatic tNoneActive;
    runOp("R1 prefill", 64'h0000_0000_0000_8000, 1'b0, 64'd0, 4'b1111, 5'd1);
    runOp("R3 none active", 64'h0000_0000_0000_8000, 1'b0, 64'd0, 4'b0000, 5'd1);
  endtask

  task automatic tDstWrap;
    runOp("R4 dst wrap", 64'h0000_0000_0001_0000, 1'b0, 64'd2, 4'b1000, 5'd30);
  endtask

  task automatic tAddrWrap;
    runOp("R9 address wrap", 64'hFFFF_FFFF_FFFF_FFE0, 1'b0, 64'd1, 4'b0011, 5'd12);
  endtask

  task automatic tIllegal;
    logic [VEC_BITS-1:0] v0;
    logic [4:0] d0;
    int rc0;
    runOp("R5 setup", 64'h0000_0000_0000_2000, 1'b0, 64'd1, 4'b0110, 5'd7);
    v0 = vecOut1; d0 = dstReg0; rc0 = readCount;
    pulseStart(64'h0000_0000_0000_3000, 1'b0, 64'd0, 5'd31, 4'b1111, 5'd20);
    chk(illegalOp, "R5 illegal flag", 256'(illegalOp), 1);
    @(negedge clk);
    chk(!illegalOp, "R5 illegal one cycle", 256'(illegalOp), 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (doneStrobe) chk(1'b0, "R5 no done after refusal", 1, 0);
    end
    chk(readCount == rc0, "R5 no reads", 256'(readCount), 256'(rc0));
    chk(vecOut1 == v0 && dstReg0 == d0, "R5 results kept", vecOut1, v0);
  endtask

  task automatic tAlign;
    int rc0;
    rc0 = readCount;
    pulseStart(64'h0000_0000_0000_4008, 1'b1, 64'd0, 5'd4, 4'b0010, 5'd5);
    chk(alignErr, "R6 align flag", 256'(alignErr), 1);
    @(negedge clk);
    chk(!alignErr, "R6 align one cycle", 256'(alignErr), 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (doneStrobe) chk(1'b0, "R6 no done after refusal", 1, 0);
    end
    chk(readCount == rc0, "R6 no reads", 256'(readCount), 256'(rc0));
    runOp("R6 misaligned sp no active", 64'h0000_0000_0000_4008, 1'b1, 64'd0, 4'b0000, 5'd6);
    chk(!alignErr, "R6 no flag when mask clear", 256'(alignErr), 0);
    runOp("R6 aligned sp", 64'h0000_0000_0000_4010, 1'b1, 64'd3, 4'b1001, 5'd6);
  endtask

  task automatic tBusyStart;
    int rc0;
    bit seen;
    rc0 = readCount;
    buildExp(64'h0000_0000_0000_6000, 64'd4, 4'b1111);
    pulseStart(64'h0000_0000_0000_6000, 1'b0, 64'd4, 5'd4, 4'b1111, 5'd10);
    repeat (3) @(negedge clk);
    startReq = 1'b1; baseAddr = 64'h0000_0000_0000_9000; predMask = 4'b0001;
    dstSel = 5'd25; idxSel = 5'd31;
    @(negedge clk);
    startReq = 1'b0;
    chk(!illegalOp, "R8 busy start no flag", 256'(illegalOp), 0);
    waitDone("R8 busy start", seen);
    verifyOp("R8 busy start ignored", rc0, 5'd10);
    repeat (6) @(negedge clk);
    chk(vecOut0 == expVec[0] && vecOut2 == expVec[2], "R8 results stable after done",
        vecOut0, expVec[0]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tAllActive();
    tMixed();
    tNoneActive();
    tDstWrap();
    tAddrWrap();
    tIllegal();
    tAlign();
    tBusyStart();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule